// File: doc/BRIEF.md
# Pixel Array Hit Timestamp and Energy Readout Scheduler

This block is the digital back end for a square array of self-triggered detector pixels. Each pixel raises a discriminator level when a particle deposits charge. On the first cycle the level is seen high, the block stores the current value of a shared free-running 1 ns time counter for that pixel and marks the pixel as waiting. A round-robin picker then takes waiting pixels one at a time. For each one it starts that pixel's 10-bit energy converter and waits for the result. It then offers a record carrying the pixel's linear index, its stored time of hit, the energy code and a count of extra triggers.

There is only ever one conversion in flight. The output is a valid/ready stream, and the scheduler does not pick the next pixel until the current record has been taken. A pixel that fires again while it is still waiting keeps its first time of hit. Each such extra trigger is counted as pileup.

Top module: `hitpix_scheduler`

## Requirements
- R1: After reset, `rec_valid_o` and `conv_start_o` are low, no pixel is waiting, and with no hits no conversion is ever started.
- R2: A pixel's stored time of hit is the `time_i` value present in the cycle in which its `hit_i` bit is first seen high after being low. A level held high for several cycles produces exactly one event.
- R3: A rising edge on a pixel that is already waiting leaves its stored time unchanged. It increments that pixel's pileup count, which saturates at 7 (3-bit field) and is reported in `rec_pileup_o`.
- R4: Pixel index is row*10+column (0..99) and is bit position in `hit_i`. After serving index k, the next grant goes to the lowest waiting index above k, wrapping past 99 to 0. The first grant after reset scans from index 0.
- R5: `conv_start_o` is a single-cycle pulse in the cycle after the scheduler picks a pixel, with `conv_idx_o` naming it. Only one conversion is outstanding at a time.
- R6: The energy code is `conv_code_i` sampled in a cycle where `conv_done_i` is high while a conversion is outstanding and the start pulse has ended. The record becomes valid in the next cycle. `conv_done_i` at any other time has no effect.
- R7: While `rec_valid_o` is high and `rec_ready_i` is low, all record fields hold still and no new conversion starts.
- R8: A picked pixel stops waiting when it is picked. A rising edge in that very cycle makes it wait again, with the new time and a pileup count of zero.
- R9: Every record carries a 7-bit index in the range 0..99 together with the 24-bit time of hit and 10-bit energy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 100 | Discriminator level per pixel, bit = row*10+column |
| time_i | input | 24 | Free-running 1 ns time counter |
| conv_start_o | output | 1 | One-cycle start for the selected pixel's converter |
| conv_idx_o | output | 7 | Index of the pixel being converted |
| conv_done_i | input | 1 | Conversion result valid |
| conv_code_i | input | 10 | Energy code from the selected pixel |
| rec_valid_o | output | 1 | Event record valid |
| rec_ready_i | input | 1 | Downstream accepts the record |
| rec_idx_o | output | 7 | Record pixel index |
| rec_ts_o | output | 24 | Record time of hit |
| rec_energy_o | output | 10 | Record energy code |
| rec_pileup_o | output | 3 | Record pileup count |

## Verification
A time of hit is latched at the edge that ends the cycle in which the hit rises. A pick made at an edge shows as `conv_start_o` during the following cycle. A done accepted at an edge gives a valid record during the next cycle, and a ready accepted at an edge drops valid during the next cycle. The bench updates its own model of the waiting pixels and scheduler state right after each rising edge, using the inputs it drove half a cycle earlier. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Directed sequences pin down ordering, wrap, saturation and the same-cycle re-trigger case. Randomized hit patterns with random back-pressure and stray done pulses cover the rest.

// File: rtl/hitpix_pkg.sv
package hitpix_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_OUT  = 2'd2
    } sched_state_e;

endpackage

// File: rtl/hitpix_slot.sv
module hitpix_slot #(
    parameter int TS_W = 24,
    parameter int PU_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_i,
    input  logic [TS_W-1:0] time_i,
    input  logic            clr_i,
    output logic            pend_o,
    output logic [TS_W-1:0] ts_o,
    output logic [PU_W-1:0] pu_o
);
    localparam logic [PU_W-1:0] PU_MAX = '1;

    typedef struct packed {
        logic            prev;
        logic            pend;
        logic [TS_W-1:0] ts;
        logic [PU_W-1:0] pu;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  rise;

    always_comb begin
        slot_d      = slot_q;
        rise        = hit_i & ~slot_q.prev;
        slot_d.prev = hit_i;
        if (clr_i) begin
            slot_d.pend = 1'b0;
            slot_d.pu   = '0;
        end
        if (rise) begin
            if (slot_q.pend && !clr_i) begin
                if (slot_q.pu != PU_MAX) begin
                    slot_d.pu = slot_q.pu + 1'b1;
                end
            end else begin
                slot_d.pend = 1'b1;
                slot_d.ts   = time_i;
                slot_d.pu   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pend_o = slot_q.pend;
    assign ts_o   = slot_q.ts;
    assign pu_o   = slot_q.pu;

endmodule

// File: rtl/hitpix_rr_pick.sv
module hitpix_rr_pick #(
    parameter int N     = 100,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             any_o,
    output logic [IDX_W-1:0] gnt_o
);
    always_comb begin
        any_o = 1'b0;
        gnt_o = '0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = int'(last_i) + k;
            if (cand >= N) begin
                cand = cand - N;
            end
            if (!any_o && req_i[IDX_W'(cand)]) begin
                any_o = 1'b1;
                gnt_o = IDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/hitpix_scheduler.sv
module hitpix_scheduler #(
    parameter int ROWS = 10,
    parameter int COLS = 10,
    parameter int TS_W = 24,
    parameter int E_W  = 10,
    parameter int PU_W = 3,
    localparam int NPIX  = ROWS * COLS,
    localparam int IDX_W = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIX-1:0]  hit_i,
    input  logic [TS_W-1:0]  time_i,
    output logic             conv_start_o,
    output logic [IDX_W-1:0] conv_idx_o,
    input  logic             conv_done_i,
    input  logic [E_W-1:0]   conv_code_i,
    output logic             rec_valid_o,
    input  logic             rec_ready_i,
    output logic [IDX_W-1:0] rec_idx_o,
    output logic [TS_W-1:0]  rec_ts_o,
    output logic [E_W-1:0]   rec_energy_o,
    output logic [PU_W-1:0]  rec_pileup_o
);
    import hitpix_pkg::*;

    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(NPIX - 1);

    typedef struct packed {
        sched_state_e     st;
        logic [IDX_W-1:0] last;
        logic [IDX_W-1:0] idx;
        logic [TS_W-1:0]  ts;
        logic [PU_W-1:0]  pu;
        logic [E_W-1:0]   energy;
        logic             start;
    } sched_t;

    sched_t sch_d, sch_q;

    logic [NPIX-1:0]  slot_pend;
    logic [TS_W-1:0]  slot_ts [NPIX];
    logic [PU_W-1:0]  slot_pu [NPIX];
    logic [NPIX-1:0]  slot_clr;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    for (genvar p = 0; p < NPIX; p++) begin : g_slot
        hitpix_slot #(
            .TS_W (TS_W),
            .PU_W (PU_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (hit_i[p]),
            .time_i (time_i),
            .clr_i  (slot_clr[p]),
            .pend_o (slot_pend[p]),
            .ts_o   (slot_ts[p]),
            .pu_o   (slot_pu[p])
        );
    end

    hitpix_rr_pick #(
        .N     (NPIX),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i  (slot_pend),
        .last_i (sch_q.last),
        .any_o  (pick_any),
        .gnt_o  (pick_idx)
    );

    always_comb begin
        sch_d       = sch_q;
        sch_d.start = 1'b0;
        slot_clr    = '0;
        case (sch_q.st)
            ST_IDLE: begin
                if (pick_any) begin
                    sch_d.st          = ST_CONV;
                    sch_d.idx         = pick_idx;
                    sch_d.last        = pick_idx;
                    sch_d.ts          = slot_ts[pick_idx];
                    sch_d.pu          = slot_pu[pick_idx];
                    sch_d.start       = 1'b1;
                    slot_clr[pick_idx] = 1'b1;
                end
            end
            ST_CONV: begin
                if (conv_done_i && !sch_q.start) begin
                    sch_d.energy = conv_code_i;
                    sch_d.st     = ST_OUT;
                end
            end
            ST_OUT: begin
                if (rec_ready_i) begin
                    sch_d.st = ST_IDLE;
                end
            end
            default: begin
                sch_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sch_q.st     <= ST_IDLE;
            sch_q.last   <= LAST_INIT;
            sch_q.idx    <= '0;
            sch_q.ts     <= '0;
            sch_q.pu     <= '0;
            sch_q.energy <= '0;
            sch_q.start  <= 1'b0;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign conv_start_o = sch_q.start;
    assign conv_idx_o   = sch_q.idx;
    assign rec_valid_o  = (sch_q.st == ST_OUT);
    assign rec_idx_o    = sch_q.idx;
    assign rec_ts_o     = sch_q.ts;
    assign rec_energy_o = sch_q.energy;
    assign rec_pileup_o = sch_q.pu;

endmodule

// File: rtl/hitpix_scheduler_chk.sv
module hitpix_scheduler_chk #(
    parameter int NPIX  = 100,
    parameter int IDX_W = 7,
    parameter int TS_W  = 24,
    parameter int E_W   = 10,
    parameter int PU_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start_o,
    input logic [IDX_W-1:0] conv_idx_o,
    input logic             rec_valid_o,
    input logic             rec_ready_i,
    input logic [IDX_W-1:0] rec_idx_o,
    input logic [TS_W-1:0]  rec_ts_o,
    input logic [E_W-1:0]   rec_energy_o,
    input logic [PU_W-1:0]  rec_pileup_o
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o); // R5

    AST_START_NOT_DURING_REC: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> !rec_valid_o); // R5

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_idx_o) && $stable(rec_ts_o)
                                           && $stable(rec_energy_o) && $stable(rec_pileup_o))); // R7

    AST_NO_START_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && !rec_ready_i) |=> !conv_start_o); // R7

    AST_REC_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (int'(rec_idx_o) < NPIX)); // R9

    AST_CONV_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (int'(conv_idx_o) < NPIX)); // R4

endmodule

bind hitpix_scheduler hitpix_scheduler_chk #(
    .NPIX  (NPIX),
    .IDX_W (IDX_W),
    .TS_W  (TS_W),
    .E_W   (E_W),
    .PU_W  (PU_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start_o (conv_start_o),
    .conv_idx_o   (conv_idx_o),
    .rec_valid_o  (rec_valid_o),
    .rec_ready_i  (rec_ready_i),
    .rec_idx_o    (rec_idx_o),
    .rec_ts_o     (rec_ts_o),
    .rec_energy_o (rec_energy_o),
    .rec_pileup_o (rec_pileup_o)
);

// File: tb/hitpix_scheduler_bench.sv
module hitpix_scheduler_bench;
    localparam int NPIX = 100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [99:0]  hit = '0;
    logic [23:0]  time_v = '0;
    logic         conv_start_o;
    logic [6:0]   conv_idx_o;
    logic         conv_done = 1'b0;
    logic [9:0]   conv_code = '0;
    logic         rec_valid_o;
    logic         rec_ready = 1'b0;
    logic [6:0]   rec_idx_o;
    logic [23:0]  rec_ts_o;
    logic [9:0]   rec_energy_o;
    logic [2:0]   rec_pileup_o;

    always #4 clk = ~clk;

    hitpix_scheduler u_hitpix_scheduler (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .time_i       (time_v),
        .conv_start_o (conv_start_o),
        .conv_idx_o   (conv_idx_o),
        .conv_done_i  (conv_done),
        .conv_code_i  (conv_code),
        .rec_valid_o  (rec_valid_o),
        .rec_ready_i  (rec_ready),
        .rec_idx_o    (rec_idx_o),
        .rec_ts_o     (rec_ts_o),
        .rec_energy_o (rec_energy_o),
        .rec_pileup_o (rec_pileup_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // reference model state
    logic [99:0] m_pend = '0;
    logic [99:0] m_prev = '0;
    logic [23:0] m_ts [NPIX];
    logic [2:0]  m_pu [NPIX];
    int          m_last = NPIX - 1;
    int          m_st = 0;
    bit          m_start = 0;
    int          m_idx = 0;
    logic [23:0] m_rts = '0;
    logic [2:0]  m_rpu = '0;
    logic [9:0]  m_energy = '0;

    // converter model and stimulus state
    int          cnv_cnt = 0;
    logic [9:0]  cnv_code = '0;
    bit          stray_en = 0;
    logic [23:0] tcnt = 24'hFFFFF0;

    int log_idx[$];
    int log_ts[$];
    int log_pu[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_step();
        logic [99:0] clr;
        bit nstart;
        bit found;
        int g;
        clr = '0;
        nstart = 0;
        found = 0;
        g = 0;
        case (m_st)
            0: begin
                for (int k = 1; k <= NPIX; k++) begin
                    int c;
                    c = (m_last + k) % NPIX;
                    if (!found && m_pend[c]) begin
                        found = 1;
                        g = c;
                    end
                end
                if (found) begin
                    m_st = 1; m_idx = g; m_last = g;
                    m_rts = m_ts[g]; m_rpu = m_pu[g];
                    nstart = 1; clr[g] = 1'b1;
                end
            end
            1: if (conv_done && !m_start) begin m_energy = conv_code; m_st = 2; end
            2: if (rec_ready) m_st = 0;
            default: m_st = 0;
        endcase
        m_start = nstart;
        for (int p = 0; p < NPIX; p++) begin
            bit old_pend;
            bit rise;
            old_pend = m_pend[p];
            rise = hit[p] && !m_prev[p];
            m_prev[p] = hit[p];
            if (clr[p]) begin m_pend[p] = 1'b0; m_pu[p] = '0; end
            if (rise) begin
                if (old_pend && !clr[p]) begin
                    if (m_pu[p] != 3'd7) m_pu[p] = m_pu[p] + 3'd1;
                end else begin
                    m_pend[p] = 1'b1; m_ts[p] = time_v; m_pu[p] = '0;
                end
            end
        end
    endfunction

    task automatic compare();
        chk(conv_start_o == m_start, "R5 start pulse", conv_start_o, m_start);
        if (m_start) chk(int'(conv_idx_o) == m_idx, "R4 grant index", conv_idx_o, m_idx);
        chk(rec_valid_o == (m_st == 2), "R7 record valid", rec_valid_o, (m_st == 2));
        if (m_st == 2 && rec_valid_o) begin
            chk(int'(rec_idx_o) == m_idx, "R9 record index", rec_idx_o, m_idx);
            chk(rec_ts_o == m_rts, "R2 record time", rec_ts_o, m_rts);
            chk(rec_energy_o == m_energy, "R6 record energy", rec_energy_o, m_energy);
            chk(rec_pileup_o == m_rpu, "R3 record pileup", rec_pileup_o, m_rpu);
        end
    endtask

    task automatic conv_drive();
        conv_done = 1'b0;
        if (conv_start_o) begin
            cnv_cnt = 1 + int'($urandom % 4);
            cnv_code = 10'($urandom);
        end else if (cnv_cnt > 0) begin
            cnv_cnt--;
            if (cnv_cnt == 0) begin
                conv_done = 1'b1;
                conv_code = cnv_code;
            end
        end else if (stray_en && ($urandom % 8 == 0)) begin
            conv_done = 1'b1;
            conv_code = 10'($urandom);
        end
    endtask

    task automatic step(input logic [99:0] h, input bit rdy);
        hit = h;
        rec_ready = rdy;
        time_v = tcnt;
        tcnt = tcnt + 24'd1;
        if (rec_valid_o && rdy) begin
            log_idx.push_back(int'(rec_idx_o));
            log_ts.push_back(int'(rec_ts_o));
            log_pu.push_back(int'(rec_pileup_o));
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        conv_drive();
    endtask

    task automatic run_idle(input int n, input bit rdy);
        for (int i = 0; i < n; i++) step('0, rdy);
    endtask

    function automatic logic [99:0] bit_of(input int p);
        logic [99:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    task automatic clear_log();
        log_idx.delete(); log_ts.delete(); log_pu.delete();
    endtask

    task automatic chk_log(input int pos, input int idx, input int ts, input int pu, input string req);
        if (log_idx.size() <= pos) begin
            chk(0, req, log_idx.size(), pos + 1);
        end else begin
            chk(log_idx[pos] == idx, req, log_idx[pos], idx);
            chk(log_ts[pos] == ts, req, log_ts[pos], ts);
            chk(log_pu[pos] == pu, req, log_pu[pos], pu);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [99:0] hstate;
        int t0, t1, t30, ta, tb;
        void'($urandom(32'h00C0FFEE));
        for (int p = 0; p < NPIX; p++) begin m_ts[p] = '0; m_pu[p] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and no spontaneous activity
        chk(rec_valid_o == 1'b0, "R1 valid after reset", rec_valid_o, 0);
        chk(conv_start_o == 1'b0, "R1 start after reset", conv_start_o, 0);
        for (int i = 0; i < 5; i++) begin
            step('0, 1);
            chk(conv_start_o == 1'b0, "R1 idle no start", conv_start_o, 0);
        end

        // R2 / R4: simultaneous hits, level held, served from index 0 up
        clear_log();
        t0 = int'(tcnt);
        for (int i = 0; i < 3; i++) step(bit_of(3) | bit_of(7) | bit_of(55), 1);
        run_idle(40, 1);
        chk(log_idx.size() == 3, "R2 one event per level", log_idx.size(), 3);
        chk_log(0, 3, t0, 0, "R4 order first");
        chk_log(1, 7, t0, 0, "R4 order second");
        chk_log(2, 55, t0, 0, "R4 order third");

        // R4: wrap after index 55
        clear_log();
        t1 = int'(tcnt);
        step(bit_of(2) | bit_of(60), 1);
        run_idle(30, 1);
        chk_log(0, 60, t1, 0, "R4 after last served");
        chk_log(1, 2, t1, 0, "R4 wrap to low index");

        // R3 / R7: pileup saturation behind a stalled record
        clear_log();
        step(bit_of(20), 0);
        run_idle(8, 0);
        t30 = int'(tcnt);
        for (int i = 0; i < 10; i++) begin
            step(bit_of(30), 0);
            step('0, 0);
        end
        run_idle(3, 0);
        chk(rec_valid_o && rec_idx_o == 7'd20, "R7 record held while stalled", rec_idx_o, 20);
        run_idle(30, 1);
        chk(log_idx.size() == 2, "R3 record count", log_idx.size(), 2);
        chk_log(1, 30, t30, 7, "R3 first time kept, pileup saturated");

        // R8: re-trigger in the cycle of the pick
        clear_log();
        step(bit_of(41), 0);
        run_idle(8, 0);
        ta = int'(tcnt);
        step(bit_of(40), 0);
        run_idle(3, 0);
        step('0, 1);
        tb = int'(tcnt);
        step(bit_of(40), 0);
        run_idle(30, 1);
        chk(log_idx.size() == 3, "R8 record count", log_idx.size(), 3);
        chk_log(1, 40, ta, 0, "R8 first event");
        chk_log(2, 40, tb, 0, "R8 re-armed at pick");

        // R6 and mixed: random hits, back-pressure, stray done pulses
        stray_en = 1;
        hstate = '0;
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < NPIX; p++) begin
                if ($urandom % 48 == 0) hstate[p] = ~hstate[p];
            end
            step(hstate, ($urandom % 4) != 0);
        end
        for (int i = 0; i < 20000; i++) begin
            if (m_pend == '0 && m_st == 0 && cnv_cnt == 0) break;
            step('0, 1);
        end
        chk(m_pend == '0 && m_st == 0, "R6 drained", m_st, 0);
        stray_en = 0;
        run_idle(10, 1);
        chk(rec_valid_o == 1'b0 && conv_start_o == 1'b0, "R6 stray done ignored", rec_valid_o, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule